// File: doc/BRIEF.md
# Byte-Reversing Move Decoder

This block is a serial front-end decoder that takes an instruction stream one byte per valid/ready handshake. It recognises the two encodings of the byte-reversing move. One encoding loads a value from memory into a register. The other stores a value from a register into memory. The decoder accepts legacy prefixes and a REX byte, the three-byte opcode and the ModRM byte. It then pulses a one-cycle result that gives:

- the transfer direction;
- the operand size (16, 32 or 64 bits);
- the four-bit destination or source register;
- an invalid-opcode fault;
- a "not this instruction" indication;
- the number of bytes consumed.

The result also states that no status flags are written. SIB and displacement bytes, address generation and the swap itself belong to later stages.

The surrounding core holds `long_mode` and `feat_present` steady while an instruction is being fed. After a result the decoder is ready for the first byte of the next instruction.

Top module: `movrev_decoder`

## Requirements
- R1: Opcode bytes 0F 38 F0 decode as a load (`out_store`=0) and 0F 38 F1 as a store (`out_store`=1); `out_reg[2:0]` equals ModRM bits [5:3] (ModRM is the byte after the third opcode byte).
- R2: Size code on `out_size`: 0 = 16 bit, 1 = 32 bit, 2 = 64 bit. The default is 32 bit. Prefix 66h selects 16 bit. In 64-bit mode a REX byte with W (bit 3) set selects 64 bit and takes precedence over 66h.
- R3: With `long_mode`=0, bytes 40h–4Fh are not prefixes. Such a byte at the start ends decoding as not-this-instruction after one byte, and the size code is never 2.
- R4: In 64-bit mode, REX bit 2 (R) becomes `out_reg[3]`. Otherwise `out_reg[3]` is 0.
- R5: A REX byte applies only when it comes directly before 0Fh. A legacy prefix after it cancels it, and a later REX byte replaces it.
- R6: A LOCK (F0h) or REP (F3h) prefix before the opcode raises `out_fault`. The F2h prefix does not.
- R7: `out_fault` is raised when `feat_present` is 0 as the ModRM byte is taken.
- R8: A ModRM byte with mod (bits [7:6]) = 11b raises `out_fault`.
- R9: The following end decoding with `out_nomatch`=1 and `out_fault`=0:
  - a first non-prefix byte other than 0Fh;
  - a second byte other than 38h;
  - a third byte other than F0h/F1h.
- R10: `out_flags_wr` is always 0.
- R11: `out_valid` is high for exactly the one cycle after the handshake of the final byte. `in_ready` is low during that cycle. `out_len` counts every byte taken, including the final one.
- R12: If the MAX_LEN-th byte (default 15) does not complete or reject the instruction, decoding ends with `out_fault`=1, `out_nomatch`=0 and `out_len`=MAX_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction byte present |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Decoder accepts a byte |
| long_mode | input | 1 | Core is in 64-bit mode |
| feat_present | input | 1 | Byte-reversing move is implemented |
| out_valid | output | 1 | One-cycle result pulse |
| out_store | output | 1 | 1 = register to memory, 0 = memory to register |
| out_size | output | 2 | Operand size code |
| out_reg | output | 4 | Register number |
| out_fault | output | 1 | Invalid-opcode fault |
| out_nomatch | output | 1 | Byte stream is a different instruction |
| out_len | output | LEN_W | Bytes consumed |
| out_flags_wr | output | 1 | Status flags written (always 0) |

## Verification
Corrupt prefix state shows up in the very next result pulse of the instruction that carries it. A sticky LOCK/REP flag or a stale REX byte gives a wrong fault, a wrong size or a wrong register bit 3, and this error carries into the following instruction when the clear on completion is missing. A wrong sequencer state or length count shows up one cycle after the offending byte, as an early or missing pulse, a wrong `out_len` or a wrong not-this-instruction verdict. The sweeps cover every prefix mix, both modes, both feature settings, both directions and all ModRM mod values, so each such fault surfaces within a few instructions.

// File: rtl/movrev_pkg.sv
// Package: shared types and byte constants for the byte-reversing move decoder.
// Assumes the standard one-byte legacy prefix set and 40h-4Fh REX bytes.
package movrev_pkg;

    typedef enum logic [1:0] {
        ST_PFX = 2'd0,   // prefixes or first opcode byte
        ST_ESC = 2'd1,   // expecting second opcode byte
        ST_OP  = 2'd2,   // expecting third opcode byte
        ST_MRM = 2'd3    // expecting ModRM
    } dec_state_e;

    typedef enum logic [1:0] {
        SZ_16 = 2'd0,
        SZ_32 = 2'd1,
        SZ_64 = 2'd2
    } opsize_e;

    typedef struct packed {
        logic legacy;   // any legacy prefix
        logic lock;     // F0h
        logic rep;      // F3h
        logic opsz;     // 66h
        logic rex;      // 40h-4Fh in 64-bit mode
        logic esc;      // 0Fh
    } byte_class_t;

    localparam logic [7:0] B_ESC0  = 8'h0F;
    localparam logic [7:0] B_ESC1  = 8'h38;
    localparam logic [7:0] B_LOAD  = 8'hF0;
    localparam logic [7:0] B_STORE = 8'hF1;

    localparam int N_LEGACY = 11;
    localparam logic [N_LEGACY*8-1:0] LEGACY_TAB = {
        8'h66, 8'h67, 8'hF0, 8'hF2, 8'hF3,
        8'h2E, 8'h36, 8'h3E, 8'h26, 8'h64, 8'h65
    };

endpackage

// File: rtl/movrev_byte_class.sv
// Module: combinational classifier of one instruction byte in prefix position.
// Assumes REX bytes exist only when long_mode_i is high.
module movrev_byte_class
    import movrev_pkg::*;
(
    input  logic [7:0]  byte_i,
    input  logic        long_mode_i,
    output byte_class_t cls_o
);

    // Purpose: match the byte against the prefix table and fixed codes.
    always_comb begin
        cls_o = '0;
        for (int i = 0; i < N_LEGACY; i++) begin
            if (byte_i == LEGACY_TAB[i*8 +: 8]) begin
                cls_o.legacy = 1'b1;
            end
        end
        cls_o.lock = (byte_i == 8'hF0);
        cls_o.rep  = (byte_i == 8'hF3);
        cls_o.opsz = (byte_i == 8'h66);
        cls_o.rex  = long_mode_i && (byte_i[7:4] == 4'h4);
        cls_o.esc  = (byte_i == B_ESC0);
    end

endmodule

// File: rtl/movrev_ctrl.sv
// Module: byte sequencer. It walks prefixes, opcode and ModRM, accumulates
// prefix state, and flags the byte that ends decoding (fin_o) in the cycle
// it is taken. Assumes long_mode_i/feat_i are steady across an instruction.
module movrev_ctrl
    import movrev_pkg::*;
#(
    parameter int MAX_LEN = 15,
    parameter int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic [7:0]       byte_i,
    input  byte_class_t      cls_i,
    input  logic             feat_i,
    output logic             fin_o,
    output logic             nomatch_o,
    output logic             fault_o,
    output logic             store_o,
    output logic             rex_w_o,
    output logic             rex_r_o,
    output logic             opsz_o,
    output logic [2:0]       reg_lo_o,
    output logic [LEN_W-1:0] len_o
);

    localparam logic [LEN_W-1:0] CAP_IDX = LEN_W'(MAX_LEN - 1);

    dec_state_e       state_q, state_d;
    logic [LEN_W-1:0] len_q, len_d;
    logic             lock_q, lock_d, rep_q, rep_d, opsz_q, opsz_d;
    logic             rexp_v_q, rexp_v_d, rexp_w_q, rexp_w_d, rexp_r_q, rexp_r_d;
    logic             op_w_q, op_w_d, op_r_q, op_r_d;
    logic             store_q, store_d;

    // Purpose: next-state, accumulation and end-of-decode decision per byte.
    always_comb begin
        state_d  = state_q;
        len_d    = len_q;
        lock_d   = lock_q;
        rep_d    = rep_q;
        opsz_d   = opsz_q;
        rexp_v_d = rexp_v_q;
        rexp_w_d = rexp_w_q;
        rexp_r_d = rexp_r_q;
        op_w_d   = op_w_q;
        op_r_d   = op_r_q;
        store_d  = store_q;
        fin_o     = 1'b0;
        nomatch_o = 1'b0;
        fault_o   = 1'b0;
        if (take_i) begin
            unique case (state_q)
                ST_PFX: begin
                    if (cls_i.esc) begin
                        state_d = ST_ESC;
                        op_w_d  = rexp_v_q & rexp_w_q;
                        op_r_d  = rexp_v_q & rexp_r_q;
                    end else if (cls_i.legacy) begin
                        lock_d   = lock_q | cls_i.lock;
                        rep_d    = rep_q | cls_i.rep;
                        opsz_d   = opsz_q | cls_i.opsz;
                        rexp_v_d = 1'b0;
                    end else if (cls_i.rex) begin
                        rexp_v_d = 1'b1;
                        rexp_w_d = byte_i[3];
                        rexp_r_d = byte_i[2];
                    end else begin
                        fin_o     = 1'b1;
                        nomatch_o = 1'b1;
                    end
                end
                ST_ESC: begin
                    if (byte_i == B_ESC1) begin
                        state_d = ST_OP;
                    end else begin
                        fin_o     = 1'b1;
                        nomatch_o = 1'b1;
                    end
                end
                ST_OP: begin
                    if (byte_i == B_LOAD || byte_i == B_STORE) begin
                        state_d = ST_MRM;
                        store_d = byte_i[0];
                    end else begin
                        fin_o     = 1'b1;
                        nomatch_o = 1'b1;
                    end
                end
                default: begin
                    fin_o   = 1'b1;
                    fault_o = lock_q | rep_q | ~feat_i | (byte_i[7:6] == 2'b11);
                end
            endcase
            if (!fin_o && len_q == CAP_IDX) begin
                fin_o   = 1'b1;
                fault_o = 1'b1;
            end
            if (fin_o) begin
                state_d  = ST_PFX;
                len_d    = '0;
                lock_d   = 1'b0;
                rep_d    = 1'b0;
                opsz_d   = 1'b0;
                rexp_v_d = 1'b0;
                op_w_d   = 1'b0;
                op_r_d   = 1'b0;
            end else begin
                len_d = len_q + 1'b1;
            end
        end
    end

    // Purpose: state and accumulator registers, synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_PFX;
            len_q    <= '0;
            lock_q   <= 1'b0;
            rep_q    <= 1'b0;
            opsz_q   <= 1'b0;
            rexp_v_q <= 1'b0;
            rexp_w_q <= 1'b0;
            rexp_r_q <= 1'b0;
            op_w_q   <= 1'b0;
            op_r_q   <= 1'b0;
            store_q  <= 1'b0;
        end else begin
            state_q  <= state_d;
            len_q    <= len_d;
            lock_q   <= lock_d;
            rep_q    <= rep_d;
            opsz_q   <= opsz_d;
            rexp_v_q <= rexp_v_d;
            rexp_w_q <= rexp_w_d;
            rexp_r_q <= rexp_r_d;
            op_w_q   <= op_w_d;
            op_r_q   <= op_r_d;
            store_q  <= store_d;
        end
    end

    // Purpose: expose the fields the result stage needs.
    assign store_o  = store_q;
    assign rex_w_o  = op_w_q;
    assign rex_r_o  = op_r_q;
    assign opsz_o   = opsz_q;
    assign reg_lo_o = byte_i[5:3];
    assign len_o    = len_q + 1'b1;

endmodule

// File: rtl/movrev_result.sv
// Module: result stage. It registers the decode outcome for one cycle and
// derives the size code and the four-bit register. Assumes fin_i lasts one cycle.
module movrev_result
    import movrev_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fin_i,
    input  logic             nomatch_i,
    input  logic             fault_i,
    input  logic             store_i,
    input  logic             rex_w_i,
    input  logic             rex_r_i,
    input  logic             opsz_i,
    input  logic [2:0]       reg_lo_i,
    input  logic [LEN_W-1:0] len_i,
    output logic             valid_o,
    output logic             store_o,
    output logic [1:0]       size_o,
    output logic [3:0]       reg_o,
    output logic             fault_o,
    output logic             nomatch_o,
    output logic [LEN_W-1:0] len_o
);

    opsize_e size_c;

    // Purpose: REX.W wins over 66h, 66h wins over the 32-bit default.
    always_comb begin
        if (rex_w_i)     size_c = SZ_64;
        else if (opsz_i) size_c = SZ_16;
        else             size_c = SZ_32;
    end

    // Purpose: one-cycle result register, fields cleared on a non-match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o   <= 1'b0;
            store_o   <= 1'b0;
            size_o    <= 2'd0;
            reg_o     <= '0;
            fault_o   <= 1'b0;
            nomatch_o <= 1'b0;
            len_o     <= '0;
        end else begin
            valid_o <= fin_i;
            if (fin_i) begin
                nomatch_o <= nomatch_i;
                fault_o   <= fault_i;
                len_o     <= len_i;
                if (nomatch_i) begin
                    store_o <= 1'b0;
                    size_o  <= 2'd0;
                    reg_o   <= '0;
                end else begin
                    store_o <= store_i;
                    size_o  <= size_c;
                    reg_o   <= {rex_r_i, reg_lo_i};
                end
            end
        end
    end

endmodule

// File: rtl/movrev_decoder.sv
// Module: top of the byte-reversing move decoder. It takes one byte per
// valid/ready handshake and pulses a result. It stalls input for the result cycle.
module movrev_decoder
    import movrev_pkg::*;
#(
    parameter  int MAX_LEN = 15,
    localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             in_ready,
    input  logic             long_mode,
    input  logic             feat_present,
    output logic             out_valid,
    output logic             out_store,
    output logic [1:0]       out_size,
    output logic [3:0]       out_reg,
    output logic             out_fault,
    output logic             out_nomatch,
    output logic [LEN_W-1:0] out_len,
    output logic             out_flags_wr
);

    byte_class_t      cls;
    logic             take, fin, nm, flt, st, rw, rr, osz;
    logic [2:0]       rlo;
    logic [LEN_W-1:0] len;

    // Purpose: handshake, with no byte accepted while a result is shown.
    assign in_ready     = ~out_valid;
    assign take         = in_valid & in_ready;
    assign out_flags_wr = 1'b0;

    movrev_byte_class u_cls (
        .byte_i      (in_byte),
        .long_mode_i (long_mode),
        .cls_o       (cls)
    );

    movrev_ctrl #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .take_i    (take),
        .byte_i    (in_byte),
        .cls_i     (cls),
        .feat_i    (feat_present),
        .fin_o     (fin),
        .nomatch_o (nm),
        .fault_o   (flt),
        .store_o   (st),
        .rex_w_o   (rw),
        .rex_r_o   (rr),
        .opsz_o    (osz),
        .reg_lo_o  (rlo),
        .len_o     (len)
    );

    movrev_result #(.LEN_W(LEN_W)) u_res (
        .clk       (clk),
        .rst_n     (rst_n),
        .fin_i     (fin),
        .nomatch_i (nm),
        .fault_i   (flt),
        .store_i   (st),
        .rex_w_i   (rw),
        .rex_r_i   (rr),
        .opsz_i    (osz),
        .reg_lo_i  (rlo),
        .len_i     (len),
        .valid_o   (out_valid),
        .store_o   (out_store),
        .size_o    (out_size),
        .reg_o     (out_reg),
        .fault_o   (out_fault),
        .nomatch_o (out_nomatch),
        .len_o     (out_len)
    );

endmodule

// File: rtl/movrev_checker.sv
// Module: port-level properties of the decoder, bound to every instance.
// Assumes long_mode and feat_present are steady within an instruction.
module movrev_checker #(
    parameter int LEN_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       in_byte,
    input logic             in_ready,
    input logic             long_mode,
    input logic             feat_present,
    input logic             out_valid,
    input logic [1:0]       out_size,
    input logic [3:0]       out_reg,
    input logic             out_fault,
    input logic             out_nomatch,
    input logic [LEN_W-1:0] out_len
);

    p_pulse_once_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);

    p_stall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);

    p_len_nonzero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_len != '0);

    p_size_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_size != 2'd3);

    p_legacy_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_nomatch && !$past(long_mode)) |-> (out_size != 2'd2 && !out_reg[3]));

    p_reg_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_nomatch && !out_fault) |-> out_reg[2:0] == $past(in_byte[5:3]));

    p_feature_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_nomatch && !$past(feat_present)) |-> out_fault);

    p_regreg_form_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_nomatch && $past(in_byte[7:6]) == 2'b11) |-> out_fault);

    p_nomatch_clean_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_nomatch) |-> !out_fault);

endmodule

bind movrev_decoder movrev_checker #(.LEN_W(LEN_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_byte      (in_byte),
    .in_ready     (in_ready),
    .long_mode    (long_mode),
    .feat_present (feat_present),
    .out_valid    (out_valid),
    .out_size     (out_size),
    .out_reg      (out_reg),
    .out_fault    (out_fault),
    .out_nomatch  (out_nomatch),
    .out_len      (out_len)
);

// File: tb/tb_movrev_decoder.sv
module tb_movrev_decoder;

    localparam int LW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_byte = 8'h00;
    logic          in_ready;
    logic          long_mode = 1'b0;
    logic          feat_present = 1'b1;
    logic          out_valid, out_store, out_fault, out_nomatch, out_flags_wr;
    logic [1:0]    out_size;
    logic [3:0]    out_reg;
    logic [LW-1:0] out_len;

    int   nvec = 0;
    int   nbad = 0;
    bit   done = 1'b0;
    logic [7:0] sq [0:15];
    int   n;

    always #4 clk = ~clk;

    movrev_decoder dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .long_mode(long_mode), .feat_present(feat_present),
        .out_valid(out_valid), .out_store(out_store), .out_size(out_size),
        .out_reg(out_reg), .out_fault(out_fault), .out_nomatch(out_nomatch),
        .out_len(out_len), .out_flags_wr(out_flags_wr)
    );

    task automatic chk(input string tag, input int got, input int exp);
        nvec++;
        if (got != exp) begin
            nbad++;
            $display("FAIL %s: got %0h expected %0h (t=%0t)", tag, got, exp, $time);
        end
    endtask

    // Feed sq[0..n-1] back-to-back; returns just after the result edge.
    task automatic run_seq();
        for (int i = 0; i < n; i++) begin
            in_byte  = sq[i];
            in_valid = 1'b1;
            @(posedge clk); #1;
            if (i < n - 1) chk("R11 early pulse", out_valid, 0);
        end
        in_valid = 1'b0;
        chk("R11 pulse", out_valid, 1);
        chk("R11 stall", in_ready, 0);
        chk("R10 flags", out_flags_wr, 0);
    endtask

    task automatic idle();
        @(posedge clk); #1;
        chk("R11 single cycle", out_valid, 0);
        chk("R11 ready back", in_ready, 1);
    endtask

    task automatic exp_match(input string tag, input int st, input int sz,
                             input int rg, input int flt, input int ln);
        chk({tag, " nomatch"}, out_nomatch, 0);
        chk({tag, " store"}, out_store, st);
        chk({tag, " size"}, out_size, sz);
        chk({tag, " reg"}, out_reg, rg);
        chk({tag, " fault"}, out_fault, flt);
        chk({tag, " len"}, out_len, ln);
    endtask

    task automatic exp_nomatch(input string tag, input int ln);
        chk({tag, " nomatch"}, out_nomatch, 1);
        chk({tag, " fault"}, out_fault, 0);
        chk({tag, " len"}, out_len, ln);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk("R11 reset valid", out_valid, 0);
        chk("R11 reset ready", in_ready, 1);

        // Sweep: mode x feature x prefix mix x REX x direction x ModRM (R1 R2 R4 R6 R7 R8).
        for (int lm = 0; lm < 2; lm++)
        for (int ft = 0; ft < 2; ft++)
        for (int pf = 0; pf < 16; pf++)
        for (int rx = 0; rx < 5; rx++)
        for (int op = 0; op < 2; op++)
        for (int md = 0; md < 4; md++) begin
            int rg3, w, r, sz, flt, reg4;
            if (lm == 0 && rx != 0) continue;
            long_mode = lm[0];
            feat_present = ft[0];
            n = 0;
            if (pf[0]) begin sq[n] = 8'h66; n++; end
            if (pf[1]) begin sq[n] = 8'hF0; n++; end
            if (pf[2]) begin sq[n] = 8'hF3; n++; end
            if (pf[3]) begin sq[n] = 8'hF2; n++; end
            w = 0; r = 0;
            if (rx != 0) begin
                sq[n] = 8'h40 | 8'((rx - 1) << 2);
                w = ((rx - 1) >> 1) & 1;
                r = (rx - 1) & 1;
                n++;
            end
            rg3 = (md * 3 + pf + rx) % 8;
            sq[n] = 8'h0F; n++;
            sq[n] = 8'h38; n++;
            sq[n] = 8'hF0 | 8'(op); n++;
            sq[n] = 8'((md << 6) | (rg3 << 3) | ((pf + op) & 7)); n++;
            sz   = w ? 2 : (pf[0] ? 0 : 1);
            reg4 = r * 8 + rg3;
            flt  = (pf[1] || pf[2] || ft == 0 || md == 3) ? 1 : 0;
            run_seq();
            exp_match("R1 R2 R4 R6 R7 R8 sweep", op, sz, reg4, flt, n);
            idle();
        end

        // R3: outside 64-bit mode, 40h-4Fh is an ordinary byte.
        long_mode = 1'b0; feat_present = 1'b1;
        for (int b = 8'h40; b <= 8'h4F; b++) begin
            sq[0] = 8'(b); n = 1;
            run_seq();
            exp_nomatch("R3 no REX", 1);
            idle();
        end
        sq[0] = 8'h0F; sq[1] = 8'h38; sq[2] = 8'hF0; sq[3] = 8'h38; n = 4;
        run_seq(); exp_match("R3 size 32", 0, 1, 7, 0, 4); idle();

        // R9: wrong third byte (LOCK present, still no fault), wrong second, wrong first.
        long_mode = 1'b1;
        for (int b = 0; b < 256; b++) begin
            if (b == 8'hF0 || b == 8'hF1) continue;
            sq[0] = 8'hF0; sq[1] = 8'h0F; sq[2] = 8'h38; sq[3] = 8'(b); n = 4;
            run_seq(); exp_nomatch("R9 third byte", 4); idle();
        end
        sq[0] = 8'h0F; sq[1] = 8'h3A; n = 2;
        run_seq(); exp_nomatch("R9 second byte", 2); idle();
        sq[0] = 8'h66; sq[1] = 8'h90; n = 2;
        run_seq(); exp_nomatch("R9 first byte", 2); idle();

        // R5: REX cancelled by a later legacy prefix, replaced by a later REX.
        sq[0] = 8'h48; sq[1] = 8'h66; sq[2] = 8'h0F; sq[3] = 8'h38; sq[4] = 8'hF0; sq[5] = 8'h05; n = 6;
        run_seq(); exp_match("R5 cancel W", 0, 0, 0, 0, 6); idle();
        sq[0] = 8'h4C; sq[1] = 8'hF2; sq[2] = 8'h0F; sq[3] = 8'h38; sq[4] = 8'hF1; sq[5] = 8'h08; n = 6;
        run_seq(); exp_match("R5 cancel R", 1, 1, 1, 0, 6); idle();
        sq[0] = 8'h48; sq[1] = 8'h44; sq[2] = 8'h0F; sq[3] = 8'h38; sq[4] = 8'hF1; sq[5] = 8'h10; n = 6;
        run_seq(); exp_match("R5 last REX", 1, 1, 10, 0, 6); idle();

        // R12: exactly MAX_LEN bytes completes; MAX_LEN without completion faults.
        for (int i = 0; i < 11; i++) sq[i] = 8'h2E;
        sq[11] = 8'h0F; sq[12] = 8'h38; sq[13] = 8'hF0; sq[14] = 8'h00; n = 15;
        run_seq(); exp_match("R12 fits", 0, 1, 0, 0, 15); idle();
        for (int i = 0; i < 14; i++) sq[i] = 8'h2E;
        sq[14] = 8'h0F; n = 15;
        run_seq();
        chk("R12 cap fault", out_fault, 1);
        chk("R12 cap nomatch", out_nomatch, 0);
        chk("R12 cap len", out_len, 15);
        idle();
        sq[0] = 8'h0F; sq[1] = 8'h38; sq[2] = 8'hF1; sq[3] = 8'h18; n = 4;
        run_seq(); exp_match("R12 clean after cap", 1, 1, 3, 0, 4); idle();

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule